// File: doc/BRIEF.md
# Per-Destination Logical Channel Transmit Scheduler

This block holds packet descriptors that are ready to go out on a switched link. Each descriptor carries a buffer base address, a length and a completion-interrupt flag. Descriptors are sorted into logical channels. A channel is a first-in first-out queue of packets bound for one destination, and the enqueuing agent picks it with a channel index. The scheduler offers the head of one channel at a time to the media access logic. The media side answers each offer in one of two ways. It reports a successful transmission, which retires the packet. Or it reports a refused or busy connection, which sends that channel into a timed backoff. During the backoff every other channel keeps being served, so one blocked destination cannot stall traffic bound elsewhere.

Channels that hold a packet and are not backing off are served round-robin. The search starts just after the channel that got the last response. Every successful transmission raises a completion pulse. An interrupt comes with it only when the retired descriptor asked for one, so reliable transports can skip interrupts and rely on their own acknowledgements.

Top module: `lchan_tx_sched`

## Requirements
- R1: After reset, `offerValid`, `cmplValid` and `cmplIrq` are low and every bit of `chanFull` is low.
- R2: A descriptor presented with `enqValid` high joins the tail of channel `enqChan`. Bit c of `chanFull` is high exactly when channel c holds DEPTH descriptors. A descriptor sent to a full channel is dropped and leaves that channel's contents unchanged.
- R3: An offer (`offerValid` high with `offerChan`, `offerBase`, `offerLen`, `offerIrq`) holds steady until the media side answers it with `mediaDone` or `mediaRefused`. `mediaDone` and `mediaRefused` are ignored in any cycle with no offer.
- R4: When no offer is pending, an offer is raised in the next cycle for the first eligible channel, searching upward with wrap-around from the channel that received the most recent response. A channel is eligible when it is non-empty and not backing off. After reset the search starts at channel 0.
- R5: Within each channel, descriptors are offered in the order they were accepted, with the base, length and flag they were enqueued with.
- R6: A refusal ends the offer and leaves the head descriptor in place. The channel then backs off for `boCycles` cycles. If the channel stays the only candidate, its next offer appears `boCycles`+2 cycles after the refusal is sampled, and other channels may be served in the meantime.
- R7: `mediaDone` on a pending offer pops that channel's head. In the next cycle it produces a one-cycle `cmplValid` with `cmplChan` set to that channel. `cmplIrq` is high in that cycle only if the retired descriptor's flag was 1, and it is never high without `cmplValid`.
- R8: When `mediaDone` and `mediaRefused` are both high on a pending offer, it is treated as a successful transmission.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enqValid | input | 1 | Descriptor enqueue strobe |
| enqChan | input | CH_W (2) | Destination channel of the descriptor |
| enqBase | input | ADDR_W (32) | Packet buffer base address |
| enqLen | input | LEN_W (16) | Packet length |
| enqIrq | input | 1 | Request an interrupt on completion |
| chanFull | output | NUM_CH (4) | Per-channel full flags |
| boCycles | input | BO_W (8) | Backoff length after a refusal, in cycles |
| offerValid | output | 1 | A head descriptor is being offered to the media side |
| offerChan | output | CH_W (2) | Channel of the offered descriptor |
| offerBase | output | ADDR_W (32) | Buffer base of the offered descriptor |
| offerLen | output | LEN_W (16) | Length of the offered descriptor |
| offerIrq | output | 1 | Interrupt flag of the offered descriptor |
| mediaDone | input | 1 | Offered packet was sent |
| mediaRefused | input | 1 | Connection for the offered packet was refused or busy |
| cmplValid | output | 1 | One-cycle completion pulse |
| cmplChan | output | CH_W (2) | Channel of the completed packet |
| cmplIrq | output | 1 | Completion interrupt |

## Verification
The bench fills a channel past its depth. A design that wrongly accepted the extra descriptor would overwrite an unsent entry, and a later offer would show the wrong base. It times the return of a refused channel that is the only candidate, where an off-by-one counter shifts the re-offer by a cycle. It also drives done while no offer is pending, which a careless design would turn into a stray pop that swallows the next packet. Random traffic with mixed refusals and simultaneous done-and-refused answers checks the round-robin order against a reference model. A design that restarted the search at channel 0, or forgot to move the pointer on a refusal, would offer the wrong channel. One that let refusal win over done would leave a packet to be sent twice.

// File: rtl/lcs_pkg.sv
package lcs_pkg;
  // strobes from the control to the datapath
  typedef struct packed {
    logic loadOffer;  // capture pickChan as the new offer
    logic dropOffer;  // offer refused: clear it, keep the head
    logic popHead;    // offer sent: clear it and retire the head
  } lcs_strobe_t;
endpackage

// File: rtl/lcs_datapath.sv
module lcs_datapath
  import lcs_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
)(
  input  logic              clk,
  input  logic              rst_n,
  input  lcs_strobe_t       strobe,
  input  logic [CH_W-1:0]   pickChan,
  input  logic              enqValid,
  input  logic [CH_W-1:0]   enqChan,
  input  logic [ADDR_W-1:0] enqBase,
  input  logic [LEN_W-1:0]  enqLen,
  input  logic              enqIrq,
  output logic [NUM_CH-1:0] chanEmpty,
  output logic [NUM_CH-1:0] chanFull,
  output logic              offerValid,
  output logic [CH_W-1:0]   offerChan,
  output logic [ADDR_W-1:0] offerBase,
  output logic [LEN_W-1:0]  offerLen,
  output logic              offerIrq,
  output logic              cmplValid,
  output logic [CH_W-1:0]   cmplChan,
  output logic              cmplIrq
);
  logic [NUM_CH-1:0][ADDR_W-1:0] headBase;
  logic [NUM_CH-1:0][LEN_W-1:0]  headLen;
  logic [NUM_CH-1:0]             headIrq;

  for (genvar g = 0; g < NUM_CH; g++) begin : gChan
    logic [ADDR_W-1:0] baseMem [DEPTH];
    logic [LEN_W-1:0]  lenMem  [DEPTH];
    logic [DEPTH-1:0]  irqMem;
    logic [PTR_W-1:0]  wrPtr, rdPtr;
    logic [PTR_W:0]    fill;
    logic              doEnq, doPop;

    assign doEnq = enqValid && (enqChan == CH_W'(g)) && !chanFull[g];
    assign doPop = strobe.popHead && (offerChan == CH_W'(g));

    always_ff @(posedge clk) begin
      if (doEnq) begin
        baseMem[wrPtr] <= enqBase;
        lenMem[wrPtr]  <= enqLen;
        irqMem[wrPtr]  <= enqIrq;
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        wrPtr <= '0;
        rdPtr <= '0;
        fill  <= '0;
      end else begin
        if (doEnq) wrPtr <= (wrPtr == PTR_W'(DEPTH-1)) ? '0 : wrPtr + 1'b1;
        if (doPop) rdPtr <= (rdPtr == PTR_W'(DEPTH-1)) ? '0 : rdPtr + 1'b1;
        case ({doEnq, doPop})
          2'b10:   fill <= fill + 1'b1;
          2'b01:   fill <= fill - 1'b1;
          default: fill <= fill;
        endcase
      end
    end

    assign chanEmpty[g] = (fill == '0);
    assign chanFull[g]  = (fill == (PTR_W+1)'(DEPTH));
    assign headBase[g]  = baseMem[rdPtr];
    assign headLen[g]   = lenMem[rdPtr];
    assign headIrq[g]   = irqMem[rdPtr];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      offerValid <= 1'b0;
      offerChan  <= '0;
      cmplValid  <= 1'b0;
      cmplChan   <= '0;
      cmplIrq    <= 1'b0;
    end else begin
      if (strobe.loadOffer) begin
        offerValid <= 1'b1;
        offerChan  <= pickChan;
      end else if (strobe.popHead || strobe.dropOffer) begin
        offerValid <= 1'b0;
      end
      cmplValid <= strobe.popHead;
      cmplIrq   <= strobe.popHead && headIrq[offerChan];
      if (strobe.popHead) cmplChan <= offerChan;
    end
  end

  assign offerBase = headBase[offerChan];
  assign offerLen  = headLen[offerChan];
  assign offerIrq  = headIrq[offerChan];
endmodule

// File: rtl/lcs_control.sv
module lcs_control
  import lcs_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int BO_W   = 8,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] chanEmpty,
  input  logic              offerValid,
  input  logic [CH_W-1:0]   offerChan,
  input  logic              mediaDone,
  input  logic              mediaRefused,
  input  logic [BO_W-1:0]   boCycles,
  output lcs_strobe_t       strobe,
  output logic [CH_W-1:0]   pickChan
);
  logic [CH_W-1:0]   lastServed;
  logic [NUM_CH-1:0] elig;
  logic              pickAny;

  // per-channel backoff timers
  for (genvar g = 0; g < NUM_CH; g++) begin : gBackoff
    logic [BO_W-1:0] boCnt;
    always_ff @(posedge clk) begin
      if (!rst_n)                                          boCnt <= '0;
      else if (strobe.dropOffer && offerChan == CH_W'(g))  boCnt <= boCycles;
      else if (boCnt != '0)                                boCnt <= boCnt - 1'b1;
    end
    assign elig[g] = !chanEmpty[g] && (boCnt == '0);
  end

  // round-robin search starting just after lastServed
  always_comb begin
    pickAny  = 1'b0;
    pickChan = '0;
    for (int i = NUM_CH; i >= 1; i--) begin
      int idx;
      idx = (int'(lastServed) + i) % NUM_CH;
      if (elig[idx]) begin
        pickAny  = 1'b1;
        pickChan = CH_W'(idx);
      end
    end
  end

  always_comb begin
    strobe.popHead   = offerValid && mediaDone;
    strobe.dropOffer = offerValid && mediaRefused && !mediaDone;
    strobe.loadOffer = !offerValid && pickAny;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                                   lastServed <= CH_W'(NUM_CH-1);
    else if (strobe.popHead || strobe.dropOffer)  lastServed <= offerChan;
  end
endmodule

// File: rtl/lchan_tx_sched.sv
module lchan_tx_sched
  import lcs_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16,
  parameter int BO_W   = 8,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enqValid,
  input  logic [CH_W-1:0]   enqChan,
  input  logic [ADDR_W-1:0] enqBase,
  input  logic [LEN_W-1:0]  enqLen,
  input  logic              enqIrq,
  output logic [NUM_CH-1:0] chanFull,
  input  logic [BO_W-1:0]   boCycles,
  output logic              offerValid,
  output logic [CH_W-1:0]   offerChan,
  output logic [ADDR_W-1:0] offerBase,
  output logic [LEN_W-1:0]  offerLen,
  output logic              offerIrq,
  input  logic              mediaDone,
  input  logic              mediaRefused,
  output logic              cmplValid,
  output logic [CH_W-1:0]   cmplChan,
  output logic              cmplIrq
);
  lcs_strobe_t       strobe;
  logic [CH_W-1:0]   pickChan;
  logic [NUM_CH-1:0] chanEmpty;

  lcs_control #(.NUM_CH(NUM_CH), .BO_W(BO_W)) uCtl (
    .clk, .rst_n, .chanEmpty, .offerValid, .offerChan,
    .mediaDone, .mediaRefused, .boCycles, .strobe, .pickChan
  );

  lcs_datapath #(.NUM_CH(NUM_CH), .DEPTH(DEPTH), .ADDR_W(ADDR_W), .LEN_W(LEN_W)) uDp (
    .clk, .rst_n, .strobe, .pickChan, .enqValid, .enqChan, .enqBase, .enqLen,
    .enqIrq, .chanEmpty, .chanFull, .offerValid, .offerChan, .offerBase,
    .offerLen, .offerIrq, .cmplValid, .cmplChan, .cmplIrq
  );
endmodule

// File: rtl/lcs_checker.sv
module lcs_checker #(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 32,
  parameter int BO_W   = 8,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
)(
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_CH-1:0] chanEmpty,
  input logic              offerValid,
  input logic [CH_W-1:0]   offerChan,
  input logic [ADDR_W-1:0] offerBase,
  input logic              mediaDone,
  input logic              mediaRefused,
  input logic [BO_W-1:0]   boCycles,
  input logic              cmplValid,
  input logic              cmplIrq
);
  a_r3_offer_held: assert property (@(posedge clk) disable iff (!rst_n)
    offerValid && !mediaDone && !mediaRefused |=>
      offerValid && $stable(offerChan) && $stable(offerBase));

  a_r2_offer_from_filled: assert property (@(posedge clk) disable iff (!rst_n)
    offerValid |-> !chanEmpty[offerChan]);

  a_r7_cmpl_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    offerValid && mediaDone |=> cmplValid);

  a_r7_no_stray_cmpl: assert property (@(posedge clk) disable iff (!rst_n)
    !(offerValid && mediaDone) |=> !cmplValid);

  a_r7_irq_with_cmpl: assert property (@(posedge clk) disable iff (!rst_n)
    cmplIrq |-> cmplValid);

  a_r6_backoff_holds: assert property (@(posedge clk) disable iff (!rst_n)
    offerValid && mediaRefused && !mediaDone && boCycles != '0 |=> ##1
      !(offerValid && offerChan == $past(offerChan, 2)));
endmodule

bind lchan_tx_sched lcs_checker #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .BO_W(BO_W)) uChk (
  .clk(clk), .rst_n(rst_n), .chanEmpty(chanEmpty), .offerValid(offerValid),
  .offerChan(offerChan), .offerBase(offerBase), .mediaDone(mediaDone),
  .mediaRefused(mediaRefused), .boCycles(boCycles), .cmplValid(cmplValid),
  .cmplIrq(cmplIrq)
);

// File: tb/lchan_tx_sched_test.sv
module lchan_tx_sched_test;
  localparam int NUM_CH = 4, DEPTH = 8, ADDR_W = 32, LEN_W = 16, BO_W = 8, CH_W = 2;
  localparam int IRQ_B = ADDR_W + LEN_W;

  typedef logic [ADDR_W+LEN_W:0] ent_t;  // {irq, len, base}

  logic clk = 1'b0, rst_n = 1'b0;
  logic enqValid = 0, enqIrq = 0, mediaDone = 0, mediaRefused = 0;
  logic [CH_W-1:0] enqChan = '0;
  logic [ADDR_W-1:0] enqBase = '0;
  logic [LEN_W-1:0] enqLen = '0;
  logic [BO_W-1:0] boCycles = '0;
  logic [NUM_CH-1:0] chanFull;
  logic offerValid, offerIrq, cmplValid, cmplIrq;
  logic [CH_W-1:0] offerChan, cmplChan;
  logic [ADDR_W-1:0] offerBase;
  logic [LEN_W-1:0] offerLen;

  always #2 clk = ~clk;

  lchan_tx_sched uut (.*);

  ent_t q[NUM_CH][$];
  int bo[NUM_CH];
  int last, expOC, expCC, checks = 0, errors = 0;
  logic expOV, expCV, expCI;
  bit finished = 0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int rrPick();
    for (int i = 1; i <= NUM_CH; i++) begin
      int idx = (last + i) % NUM_CH;
      if (q[idx].size() != 0 && bo[idx] == 0) return idx;
    end
    return -1;
  endfunction

  // called at a negedge: check outputs, drive inputs, advance the model one edge
  task automatic cycle(bit eV, int eC, logic [ADDR_W-1:0] eB, logic [LEN_W-1:0] eL,
                       bit eI, bit dn, bit rf);
    int pick, boSet;
    bit enqOk, nOV, nCV;
    chk(offerValid == expOV, "R4", "offerValid", int'(offerValid), int'(expOV));
    if (expOV && offerValid) begin
      ent_t h = q[expOC][0];
      chk(offerChan == CH_W'(expOC), "R4", "offerChan", int'(offerChan), expOC);
      chk(offerBase == h[ADDR_W-1:0], "R5", "offerBase", int'(offerBase), int'(h[ADDR_W-1:0]));
      chk(offerLen == h[ADDR_W +: LEN_W], "R5", "offerLen", int'(offerLen), int'(h[ADDR_W +: LEN_W]));
      chk(offerIrq == h[IRQ_B], "R5", "offerIrq", int'(offerIrq), int'(h[IRQ_B]));
    end
    chk(cmplValid == expCV, "R7", "cmplValid", int'(cmplValid), int'(expCV));
    if (expCV) begin
      chk(cmplChan == CH_W'(expCC), "R7", "cmplChan", int'(cmplChan), expCC);
      chk(cmplIrq == expCI, "R7", "cmplIrq", int'(cmplIrq), int'(expCI));
    end else chk(cmplIrq == 1'b0, "R7", "cmplIrq idle", int'(cmplIrq), 0);
    for (int c = 0; c < NUM_CH; c++)
      chk(chanFull[c] == (q[c].size() == DEPTH), "R2", "chanFull", int'(chanFull[c]),
          int'(q[c].size() == DEPTH));
    enqValid = eV; enqChan = CH_W'(eC); enqBase = eB; enqLen = eL; enqIrq = eI;
    mediaDone = dn; mediaRefused = rf;
    pick = expOV ? -1 : rrPick();
    enqOk = eV && q[eC].size() < DEPTH;
    nOV = expOV; nCV = 0; boSet = -1;
    if (expOV && dn) begin
      nCV = 1; expCC = expOC; expCI = q[expOC][0][IRQ_B];
      void'(q[expOC].pop_front()); last = expOC; nOV = 0;
    end else if (expOV && rf) begin
      boSet = expOC; last = expOC; nOV = 0;
    end else if (!expOV && pick >= 0) begin
      nOV = 1; expOC = pick;
    end
    for (int c = 0; c < NUM_CH; c++)
      if (c == boSet) bo[c] = int'(boCycles);
      else if (bo[c] > 0) bo[c]--;
    if (enqOk) q[eC].push_back({eI, eL, eB});
    expOV = nOV; expCV = nCV;
    @(negedge clk);
  endtask

  task automatic idle(bit dn = 0); cycle(0, 0, '0, '0, 0, dn, 0); endtask

  task automatic drain();
    for (int k = 0; k < 400; k++) begin
      int tot = 0;
      for (int c = 0; c < NUM_CH; c++) tot += q[c].size();
      if (tot == 0 && !expOV) break;
      cycle(0, 0, '0, '0, 0, 1, 0);
    end
  endtask

  initial begin
    void'($urandom(32'h1c4a));
    for (int c = 0; c < NUM_CH; c++) bo[c] = 0;
    last = NUM_CH - 1; expOV = 0; expCV = 0; expOC = 0; expCC = 0; expCI = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    chk(offerValid == 0, "R1", "offerValid", int'(offerValid), 0);
    chk(cmplValid == 0, "R1", "cmplValid", int'(cmplValid), 0);
    chk(cmplIrq == 0, "R1", "cmplIrq", int'(cmplIrq), 0);
    chk(chanFull == '0, "R1", "chanFull", int'(chanFull), 0);

    // R2: overfill channel 2 while the media side stays silent
    boCycles = 8'd5;
    for (int i = 0; i < DEPTH + 1; i++) cycle(1, 2, 32'h2000 + i, 16'(64 + i), i[0], 0, 0);
    idle();
    chk(chanFull[2] == 1, "R2", "full after overfill", int'(chanFull[2]), 1);
    // R6: refuse, then drain in order (R5)
    cycle(0, 0, '0, '0, 0, 0, 1);
    drain();

    // R6 timing with a lone candidate, and R3 ignored done while no offer
    boCycles = 8'd4;
    cycle(1, 1, 32'hAB00, 16'd9, 1, 0, 0);
    for (int k = 0; k < 10 && !offerValid; k++) idle();
    cycle(0, 0, '0, '0, 0, 0, 1);
    begin
      int gap = 1;
      while (!offerValid && gap < 50) begin idle(1); gap++; end
      chk(gap == int'(boCycles) + 2, "R6", "re-offer gap", gap, int'(boCycles) + 2);
      chk(offerBase == 32'hAB00, "R3", "head kept after ignored done", int'(offerBase), 32'hAB00);
    end
    // R8: done and refused together
    cycle(0, 0, '0, '0, 0, 1, 1);
    chk(cmplValid == 1, "R8", "done wins over refuse", int'(cmplValid), 1);
    idle();

    // random traffic for R4 R5 R6 R7
    boCycles = 8'd3;
    for (int n = 0; n < 6000; n++) begin
      if (n == 3000) boCycles = 8'd0;
      cycle($urandom_range(0, 99) < 45, $urandom_range(0, NUM_CH - 1), $urandom,
            16'($urandom), $urandom_range(0, 1), $urandom_range(0, 99) < 35,
            $urandom_range(0, 99) < 25);
    end
    drain();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule